// File: doc/BRIEF.md
# Nibble-Serial Analog Pad Responder

This block answers a host on the controller side of a seven-bit game port. It streams the state of an analog pad back four bits at a time. Two stick axes (X, Y), a third single-direction axis (Z) and eight buttons are presented live on its inputs.

The host writes the port with a data byte and an output-enable mask. It toggles the select line on bit 6 to start and step acquisition. On each read it fetches one slice together with two handshake flags. Every slice is repeated over a group of four reads. One full acquisition is five sequences of eight reads.

Sequences advance on host writes, but only once the host has read enough since the last restart. They stop at the fifth sequence. A falling select line restarts everything. Two copies of the block serve two ports.

Top module: `apad_responder`

## Requirements
- R1: A synchronous high `rst` sets `rd_data` to 0x00, clears the step and read-age counters and stores the select line (bit 6) as high, so the first read after reset returns the button group 0 slice with bit 5 set.
- R2: `rd_data` is registered. It changes only in the cycle after `rd_stb` and then holds: bit 6 = 1, bit 5 = 1 only on the first read of each group of four (step bits 1:0 = 0), bit 4 = step bit 2, bits 3:0 = slice.
- R3: Each read advances the 3-bit step field (counter bits 2:0) by one, wrapping 7 to 0, and leaves the sequence field (counter bits 5:3) unchanged.
- R4: The slice is chosen by counter bits 5:2, in this order: 0 button group 0, 1 button group 1, 2 X[7:4], 3 Y[7:4], 4 zero, 5 Z[7:4], 6 X[3:0], 7 Y[3:0], 8 zero, 9 Z[3:0].
- R5: Button input `btn` is 1 when pressed, and slices report buttons inverted. Button group 0 is `btn[7:4]` and button group 1 is `btn[3:0]`, each placed with the same bit order on slice bits 3:0.
- R6: A write changes only the stored port bits whose `wr_mask` bit is 1; masked-off bits of `wr_data` are ignored, so a bit 6 of 0 with mask bit 6 clear is not a select edge.
- R7: A write that takes the stored select bit from 1 to 0 clears the counter and the read-age counter.
- R8: Any other write moves the counter to the start of the next sequence (step cleared, sequence + 1), but only when more than 2 reads have happened since the last clear; otherwise the counter is unchanged.
- R9: The sequence field never exceeds 4; a step write in sequence 4 leaves it at sequence 4, step 0.
- R10: The read-age counter saturates at its maximum instead of wrapping, so a long run of reads keeps the advance enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle host write strobe (takes precedence over a read in the same cycle) |
| wr_data | input | 7 | Host write data, bit 6 is the select line |
| wr_mask | input | 7 | Output-enable mask, 1 = bit driven by host |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_data | output | 7 | Registered read value, valid the cycle after `rd_stb` |
| stick_x | input | 8 | X axis, 128 = centre |
| stick_y | input | 8 | Y axis, 128 = centre |
| stick_z | input | 8 | Z axis |
| btn | input | 8 | Buttons, 1 = pressed |

## Verification
The hardest states to reach are the edges of the read-age guard and the counter limits. These are a write after exactly two reads and exactly three reads, a step write while already in the fifth sequence, and a write whose masked-off bit 6 is 0. The stimulus walks every sequence by chaining masked writes after five reads each, then probes the guard with reads and writes interleaved one by one. A separate run issues eighteen reads after a restart so that a wrapping four-bit age counter would read back 2. The write that follows must still advance.

// File: rtl/apad_pkg.sv
package apad_pkg;
  localparam int NIB_W   = 4;
  localparam int AXIS_W  = 2 * NIB_W;
  localparam int BTN_W   = 2 * NIB_W;
  localparam int PORT_W  = 7;
  localparam int SEL_BIT = 6;
  localparam int RDY_BIT = 5;
  localparam int HLF_BIT = 4;
  localparam int STEP_W  = 3;

  typedef enum logic [3:0] {
    SL_BTN0  = 4'd0,
    SL_BTN1  = 4'd1,
    SL_XHI   = 4'd2,
    SL_YHI   = 4'd3,
    SL_NONE0 = 4'd4,
    SL_ZHI   = 4'd5,
    SL_XLO   = 4'd6,
    SL_YLO   = 4'd7,
    SL_NONE1 = 4'd8,
    SL_ZLO   = 4'd9
  } slice_e;
endpackage

// File: rtl/apad_port_state.sv
module apad_port_state
  import apad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] wr_mask,
  output logic              th_q,
  output logic              th_fall
);
  logic [PORT_W-1:0] state_q;
  logic [PORT_W-1:0] merged;

  // only driven bits take the new value
  assign merged  = (state_q & ~wr_mask) | (wr_data & wr_mask);
  assign th_q    = state_q[SEL_BIT];
  assign th_fall = wr_stb & state_q[SEL_BIT] & ~merged[SEL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PORT_W'(1) << SEL_BIT;
    end else if (wr_stb) begin
      state_q <= merged;
    end
  end
endmodule

// File: rtl/apad_seq_ctrl.sv
module apad_seq_ctrl
  import apad_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int LAT_W    = 4,
  parameter int SEQ_LAST = 4,
  parameter int GUARD    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             th_fall,
  output logic [CNT_W-1:0] cnt_q,
  output logic [LAT_W-1:0] lat_q
);
  localparam int SEQ_W = CNT_W - STEP_W;
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic [SEQ_W-1:0]  seq_cur;
  logic [SEQ_W-1:0]  seq_nxt;
  logic [STEP_W-1:0] step_nxt;
  logic              armed;

  assign seq_cur  = cnt_q[CNT_W-1:STEP_W];
  assign seq_nxt  = (seq_cur >= SEQ_W'(SEQ_LAST)) ? SEQ_W'(SEQ_LAST) : seq_cur + 1'b1;
  assign step_nxt = cnt_q[STEP_W-1:0] + 1'b1;
  assign armed    = lat_q > LAT_W'(GUARD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else if (wr_stb) begin
      if (th_fall) begin
        cnt_q <= '0;
        lat_q <= '0;
      end else if (armed) begin
        cnt_q <= {seq_nxt, {STEP_W{1'b0}}};
      end
    end else if (rd_stb) begin
      cnt_q <= {seq_cur, step_nxt};
      if (lat_q != LAT_MAX) lat_q <= lat_q + 1'b1;
    end
  end
endmodule

// File: rtl/apad_slice_out.sv
module apad_slice_out
  import apad_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [AXIS_W-1:0] stick_x,
  input  logic [AXIS_W-1:0] stick_y,
  input  logic [AXIS_W-1:0] stick_z,
  input  logic [BTN_W-1:0]  btn,
  output logic [PORT_W-1:0] rd_data
);
  logic [3:0]       sel;
  logic [NIB_W-1:0] nib;
  logic             rdy;
  logic             half;

  assign sel  = 4'(cnt_q[CNT_W-1:2]);
  assign rdy  = (cnt_q[1:0] == 2'b00);
  assign half = cnt_q[2];

  always_comb begin
    case (slice_e'(sel))
      SL_BTN0: nib = ~btn[BTN_W-1:NIB_W];
      SL_BTN1: nib = ~btn[NIB_W-1:0];
      SL_XHI:  nib = stick_x[AXIS_W-1:NIB_W];
      SL_YHI:  nib = stick_y[AXIS_W-1:NIB_W];
      SL_ZHI:  nib = stick_z[AXIS_W-1:NIB_W];
      SL_XLO:  nib = stick_x[NIB_W-1:0];
      SL_YLO:  nib = stick_y[NIB_W-1:0];
      SL_ZLO:  nib = stick_z[NIB_W-1:0];
      default: nib = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_stb) begin
      rd_data <= {1'b1, rdy, half, nib};
    end
  end
endmodule

// File: rtl/apad_responder.sv
module apad_responder
  import apad_pkg::*;
#(
  parameter int SEQ_LAST = 4,
  parameter int LAT_W    = 4,
  parameter int GUARD    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stb,
  input  logic [6:0]  wr_data,
  input  logic [6:0]  wr_mask,
  input  logic        rd_stb,
  output logic [6:0]  rd_data,
  input  logic [7:0]  stick_x,
  input  logic [7:0]  stick_y,
  input  logic [7:0]  stick_z,
  input  logic [7:0]  btn
);
  localparam int CNT_W = $clog2((SEQ_LAST + 1) * (1 << STEP_W));

  logic             th_q;
  logic             th_fall;
  logic [CNT_W-1:0] cnt_q;
  logic [LAT_W-1:0] lat_q;

  apad_port_state u_port (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .th_q    (th_q),
    .th_fall (th_fall)
  );

  apad_seq_ctrl #(
    .CNT_W    (CNT_W),
    .LAT_W    (LAT_W),
    .SEQ_LAST (SEQ_LAST),
    .GUARD    (GUARD)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .th_fall (th_fall),
    .cnt_q   (cnt_q),
    .lat_q   (lat_q)
  );

  apad_slice_out #(
    .CNT_W (CNT_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .cnt_q   (cnt_q),
    .stick_x (stick_x),
    .stick_y (stick_y),
    .stick_z (stick_z),
    .btn     (btn),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/apad_responder_chk.sv
module apad_responder_chk #(
  parameter int CNT_W    = 6,
  parameter int LAT_W    = 4,
  parameter int SEQ_LAST = 4,
  parameter int GUARD    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             wr_th,
  input logic             wr_th_en,
  input logic [6:0]       rd_data,
  input logic             th_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [LAT_W-1:0] lat_q
);
  logic new_th;
  logic falling;
  assign new_th  = wr_th_en ? wr_th : th_q;
  assign falling = wr_stb && th_q && !new_th;

  a_r2_marker_bit: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_data[6]);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  a_r2_ready_first: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && cnt_q[1:0] == 2'b00) |=> rd_data[5]);

  a_r2_ready_rest: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && cnt_q[1:0] != 2'b00) |=> !rd_data[5]);

  a_r2_half_flag: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (rd_data[4] == $past(cnt_q[2])));

  a_r3_seq_kept: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb) |=> (cnt_q[CNT_W-1:3] == $past(cnt_q[CNT_W-1:3])));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    falling |=> (cnt_q == '0 && lat_q == '0));

  a_r9_seq_limit: assert property (@(posedge clk) disable iff (rst)
    cnt_q[CNT_W-1:3] <= (CNT_W-3)'(SEQ_LAST));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (lat_q > LAT_W'(GUARD) && !falling) |=> (lat_q > LAT_W'(GUARD)));
endmodule

bind apad_responder apad_responder_chk #(
  .CNT_W    (CNT_W),
  .LAT_W    (LAT_W),
  .SEQ_LAST (SEQ_LAST),
  .GUARD    (GUARD)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .wr_th    (wr_data[6]),
  .wr_th_en (wr_mask[6]),
  .rd_data  (rd_data),
  .th_q     (th_q),
  .cnt_q    (cnt_q),
  .lat_q    (lat_q)
);

// File: tb/apad_responder_tb_top.sv
module apad_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [6:0] wr_data = '0;
  logic [6:0] wr_mask = '0;
  logic       rd_stb = 1'b0;
  logic [6:0] rd_data;
  logic [7:0] stick_x = 8'hA5;
  logic [7:0] stick_y = 8'h3C;
  logic [7:0] stick_z = 8'hE7;
  logic [7:0] btn     = 8'b1000_0001;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  apad_responder dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .stick_x (stick_x),
    .stick_y (stick_y),
    .stick_z (stick_z),
    .btn     (btn)
  );

  // {is_write, data, mask, expected read, requirement number}
  localparam int NV = 45;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 7'h00, 7'h40, 7'h00, 4'd7},  // R7 restart
    {1'b0, 7'h00, 7'h00, 7'h67, 4'd5},  // R5 group 0 inverted
    {1'b0, 7'h00, 7'h00, 7'h47, 4'd2},
    {1'b0, 7'h00, 7'h00, 7'h47, 4'd2},
    {1'b0, 7'h00, 7'h00, 7'h47, 4'd2},
    {1'b0, 7'h00, 7'h00, 7'h7E, 4'd5},  // R5 group 1 inverted
    {1'b0, 7'h00, 7'h00, 7'h5E, 4'd2},
    {1'b0, 7'h00, 7'h00, 7'h5E, 4'd2},
    {1'b0, 7'h00, 7'h00, 7'h5E, 4'd3},  // R3 step 7, then wraps
    {1'b1, 7'h40, 7'h40, 7'h00, 4'd8},  // R8 advance to sequence 1
    {1'b0, 7'h00, 7'h00, 7'h6A, 4'd4},  // R4 X high
    {1'b0, 7'h00, 7'h00, 7'h4A, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h4A, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h4A, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h73, 4'd4},  // R4 Y high
    {1'b1, 7'h00, 7'h00, 7'h00, 4'd6},  // R6 empty mask, no edge
    {1'b0, 7'h00, 7'h00, 7'h60, 4'd4},  // R4 zero slice
    {1'b0, 7'h00, 7'h00, 7'h40, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h40, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h40, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h7E, 4'd4},  // R4 Z high
    {1'b1, 7'h00, 7'h00, 7'h00, 4'd8},
    {1'b0, 7'h00, 7'h00, 7'h65, 4'd4},  // R4 X low
    {1'b0, 7'h00, 7'h00, 7'h45, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h45, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h45, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h7C, 4'd4},  // R4 Y low
    {1'b1, 7'h00, 7'h00, 7'h00, 4'd8},
    {1'b0, 7'h00, 7'h00, 7'h60, 4'd4},  // R4 zero slice
    {1'b0, 7'h00, 7'h00, 7'h40, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h40, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h40, 4'd4},
    {1'b0, 7'h00, 7'h00, 7'h77, 4'd4},  // R4 Z low
    {1'b1, 7'h00, 7'h00, 7'h00, 4'd9},  // R9 stays in sequence 4
    {1'b0, 7'h00, 7'h00, 7'h60, 4'd9},
    {1'b1, 7'h00, 7'h3F, 7'h00, 4'd6},  // R6 bit 6 masked off
    {1'b0, 7'h00, 7'h00, 7'h60, 4'd6},
    {1'b1, 7'h00, 7'h40, 7'h00, 4'd7},  // R7 restart
    {1'b0, 7'h00, 7'h00, 7'h67, 4'd7},
    {1'b1, 7'h40, 7'h40, 7'h00, 4'd8},  // R8 one read: no advance
    {1'b0, 7'h00, 7'h00, 7'h47, 4'd8},
    {1'b1, 7'h00, 7'h00, 7'h00, 4'd8},  // R8 two reads: no advance
    {1'b0, 7'h00, 7'h00, 7'h47, 4'd8},
    {1'b1, 7'h00, 7'h00, 7'h00, 4'd8},  // R8 three reads: advance
    {1'b0, 7'h00, 7'h00, 7'h6A, 4'd8}
  };

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: rd_data=0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] d, input logic [6:0] m);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic do_read(output logic [6:0] v);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(rd_data, 7'h00, "R1 reset value");
    do_read(v);
    check(v, 7'h67, "R1 first read after reset");
    do_reset();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25]) begin
        do_write(VEC[i][24:18], VEC[i][17:11]);
      end else begin
        do_read(v);
        check(v, VEC[i][10:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
      end
    end

    // R2 output holds while idle
    repeat (4) @(negedge clk);
    check(rd_data, 7'h6A, "R2 hold between reads");

    // R1 reset mid-sequence restarts at group 0
    do_reset();
    check(rd_data, 7'h00, "R1 mid-run reset");
    do_read(v);
    check(v, 7'h67, "R1 restart slice");

    // R5 all pressed / none pressed
    btn = 8'hFF;
    do_reset();
    do_read(v);
    check(v, 7'h60, "R5 all pressed group 0");
    btn = 8'h00;
    for (int k = 0; k < 4; k++) do_read(v);
    check(v, 7'h7F, "R5 none pressed group 1");

    // R10 eighteen reads, then a step write must still advance
    btn = 8'b1000_0001;
    do_write(7'h00, 7'h40);
    for (int k = 0; k < 18; k++) do_read(v);
    check(v, 7'h47, "R3 step after 18 reads");
    do_write(7'h40, 7'h40);
    do_read(v);
    check(v, 7'h6A, "R10 age counter saturates");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule